// File: doc/BRIEF.md
# Decoder control and interrupt register

This block is the single 32-bit control and status word of a hardware picture decoder. Software writes it to start a decode run and to mask or allow the decoder's interrupt. Pulses from the decoder core then update status flags, stop the run and raise an interrupt flag. The core can report a finished picture, a stream error, a detected end of stream, a bus error response, a timeout or a finished JPEG slice. The interrupt flag passes through the mask. It is then ORed with an interrupt request from a post-processor to form the one interrupt line of the unit.

Software starts a run by writing 1 to bit 0. It waits for the interrupt line, or polls the word when interrupts are masked. It reads the status flags to learn why the run ended. It acknowledges by writing 0 to bit 8. Every write loads bits 0, 4 and 8 together, so an acknowledge normally writes back the mask bit it wants to keep. The status flags are cleared only when the next run is started.

Top module: `dec_ctrl_reg`

## Requirements
- R1: After reset, the read word is 0x00000000 and `irq_out` is 0 while `pp_irq_in` is 0.
- R2: A write loads bit 0 (run), bit 4 (interrupt mask) and bit 8 (interrupt flag) from `wr_data`. The new value is visible on `rd_data` in the cycle after the write edge. Writing 0 to bit 0 stops a run.
- R3: A pulse on `ev_pic_done`, `ev_strm_err`, `ev_strm_end`, `ev_bus_err` or `ev_timeout` clears bit 0 at the next edge. This applies even when a write with bit 0 = 1 happens in the same cycle.
- R4: Each event pulse sets its own status flag, and the flag reads 1 after the edge. The flag positions are: picture done at bit 12, bus error at bit 13, stream error at bit 14, stream end at bit 15, JPEG slice done at bit 17 and timeout at bit 18.
- R5: Any of the six event pulses sets bit 8 and also sets the interrupt-event flag at bit 16. Writing 0 to bit 8 clears bit 8. A hardware set in the same cycle as such a write wins, so bit 8 reads 1.
- R6: `irq_out` is combinationally equal to (bit 8 AND NOT bit 4) OR `pp_irq_in`.
- R7: Status bits 12 to 18 hold their values until a write with bit 0 = 1 clears them. A flag whose event arrives in the same cycle as that write is set, not cleared.
- R8: Bits 1 to 3, 5 to 7, 9 to 11 and 19 to 31 always read 0, and writes to them have no effect.
- R9: A JPEG slice-done pulse does not clear bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| ev_pic_done | input | 1 | Core pulse: picture decoded |
| ev_strm_err | input | 1 | Core pulse: stream error |
| ev_strm_end | input | 1 | Core pulse: end of stream detected |
| ev_bus_err | input | 1 | Core pulse: bus error response |
| ev_timeout | input | 1 | Core pulse: timeout |
| ev_slice_done | input | 1 | Core pulse: JPEG slice done |
| pp_irq_in | input | 1 | Post-processor interrupt request |
| irq_out | output | 1 | Combined interrupt line |

## Verification
The assertions take for granted that the event inputs are single-cycle pulses that are clean at the sampling edge. They also assume that a write is a one-cycle strobe with stable data, so that each check can look exactly one edge back.

The stimulus changes every input on the falling edge and returns the event lines to 0 after one cycle. It places the same-cycle collisions, start against terminate and acknowledge against a new interrupt, deliberately on a single edge. This keeps those corner cases within the same one-cycle pulse rule.

// File: rtl/dec_ctrl_reg.sv
module dec_ctrl_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          ev_pic_done,
  input  logic          ev_strm_err,
  input  logic          ev_strm_end,
  input  logic          ev_bus_err,
  input  logic          ev_timeout,
  input  logic          ev_slice_done,
  input  logic          pp_irq_in,
  output logic          irq_out
);

  localparam int RUN_B  = 0;
  localparam int MASK_B = 4;
  localparam int IRQ_B  = 8;
  localparam int STAT_L = 12;
  localparam int STAT_N = 7;

  logic              run_q, mask_q, irq_q;
  logic [STAT_N-1:0] stat_q, stat_set;
  logic              term, hw_irq, start;

  assign term   = ev_pic_done | ev_strm_err | ev_strm_end | ev_bus_err | ev_timeout;
  assign hw_irq = term | ev_slice_done;
  assign start  = wr_en & wr_data[RUN_B];

  assign stat_set = {ev_timeout, ev_slice_done, hw_irq, ev_strm_end,
                     ev_strm_err, ev_bus_err, ev_pic_done};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mask_q <= 1'b0;
      irq_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      if (wr_en) begin
        run_q  <= wr_data[RUN_B];
        mask_q <= wr_data[MASK_B];
        irq_q  <= wr_data[IRQ_B];
      end
      if (term)   run_q <= 1'b0;
      if (hw_irq) irq_q <= 1'b1;
      stat_q <= (start ? '0 : stat_q) | stat_set;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[RUN_B]  = run_q;
    rd_data[MASK_B] = mask_q;
    rd_data[IRQ_B]  = irq_q;
    rd_data[STAT_L +: STAT_N] = stat_q;
  end

  assign irq_out = (irq_q & ~mask_q) | pp_irq_in;

  // R3
  term_stops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> !rd_data[RUN_B]);

  // R2
  start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !term) |=> rd_data[RUN_B]);

  // R5
  irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_irq |=> (rd_data[IRQ_B] && rd_data[16]));

  // R4
  bus_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |=> rd_data[13]);

  // R7
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !hw_irq) |=> (rd_data[18:12] == '0));

  // R7
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !hw_irq) |=> $stable(rd_data[18:12]));

  // R9
  slice_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_slice_done && !term && !wr_en && rd_data[RUN_B]) |=> rd_data[RUN_B]);

  // R6
  mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[MASK_B] && !pp_irq_in) |-> !irq_out);

endmodule

// File: tb/dec_ctrl_reg_tb.sv
module dec_ctrl_reg_tb_top;
  logic        clk = 0, rst_n = 0, wr_en = 0, pp = 0;
  logic [31:0] wr_data = '0, rd_data;
  logic [5:0]  ev = '0; // {slice, timeout, bus, end, err, pic}
  logic        irq_out;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  dec_ctrl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_pic_done(ev[0]), .ev_strm_err(ev[1]), .ev_strm_end(ev[2]),
    .ev_bus_err(ev[3]), .ev_timeout(ev[4]), .ev_slice_done(ev[5]),
    .pp_irq_in(pp), .irq_out(irq_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic cyc(logic we, logic [31:0] d, logic [5:0] e);
    wr_en = we; wr_data = d; ev = e;
    @(posedge clk); @(negedge clk);
    wr_en = 0; wr_data = '0; ev = '0;
  endtask

  function automatic logic [31:0] flag_of(int i);
    case (i)
      0: return 32'h1 << 12;
      1: return 32'h1 << 14;
      2: return 32'h1 << 15;
      3: return 32'h1 << 13;
      4: return 32'h1 << 18;
      default: return 32'h1 << 17;
    endcase
  endfunction

  task automatic t_reset();
    chk("R1 word", rd_data, 32'h0);
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_start_stop();
    cyc(1, 32'h1, '0);
    chk("R2 start", rd_data, 32'h1);
    cyc(1, 32'h0, '0);
    chk("R2 stop", rd_data, 32'h0);
  endtask

  task automatic t_terminate();
    for (int i = 0; i < 5; i++) begin
      cyc(1, 32'h1, '0);
      cyc(0, 0, 6'b1 << i);
      chk("R3 R4 R5 term", rd_data, 32'h0001_0100 | flag_of(i));
      chk("R6 irq", {31'b0, irq_out}, 32'h1);
      cyc(1, 32'h0, '0);
      chk("R5 R7 ack holds flags", rd_data, 32'h0001_0000 | flag_of(i));
      chk("R6 irq low", {31'b0, irq_out}, 32'h0);
    end
  endtask

  task automatic t_slice();
    cyc(1, 32'h1, '0);
    cyc(0, 0, 6'b10_0000);
    chk("R9 R4 slice", rd_data, 32'h0003_0101);
    cyc(1, 32'h1, '0);
    chk("R7 restart clears", rd_data, 32'h1);
  endtask

  task automatic t_mask();
    cyc(1, 32'h11, '0);
    cyc(0, 0, 6'b00_0001);
    chk("R4 masked flags", rd_data, 32'h0001_1110);
    chk("R6 masked", {31'b0, irq_out}, 32'h0);
    pp = 1; #1;
    chk("R6 pp path", {31'b0, irq_out}, 32'h1);
    pp = 0; #1;
    cyc(1, 32'h100, '0);
    chk("R6 unmasked", {31'b0, irq_out}, 32'h1);
    cyc(1, 32'h0, '0);
  endtask

  task automatic t_races();
    cyc(1, 32'h1, 6'b00_1000);
    chk("R3 R7 start vs bus err", rd_data, 32'h0001_2100);
    cyc(1, 32'h0, 6'b00_0100);
    chk("R5 ack vs event", rd_data, 32'h0001_A100);
  endtask

  task automatic t_undef();
    cyc(1, 32'hFFFF_FFFF, '0);
    chk("R8 R7 all ones", rd_data, 32'h0000_0111);
    cyc(1, 32'hFFF0_EEEE, '0);
    chk("R8 undef ignored", rd_data, 32'h0000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_start_stop();
    t_terminate();
    t_slice();
    t_mask();
    t_races();
    t_undef();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule